// File: doc/BRIEF.md
# Ring-Addressed Delay FIFO

This block is a fixed-latency first-in first-out store used as the reordering memory between butterfly stages of a pipelined FFT. It holds DEPTH words and acts as a delay line: every word accepted on an enabled cycle comes back out exactly DEPTH enabled cycles later. It has no full or empty flags and no variable occupancy.

A single one-hot ring pointer does all the addressing. The set bit marks the cell written in the current cycle. The same pointer, rotated by one position, marks the next cell along the ring, which holds the oldest word, and that cell is read. Cells capture on the falling clock edge. The read word is formed by gating every cell with its select bit and OR-ing the gated words together, and it is registered on the rising edge. The intended depths are 8 and 32. Longer delays come from chaining instances, with the output of one feeding the input of the next under the same enable.

Top module: `ring_delay_line`

## Requirements
- R1: While reset is asserted, and after reset until DEPTH enabled cycles have passed, `dout` is zero, because every cell clears to zero.
- R2: With `en` high on every cycle, a word driven on `din` in cycle j is visible on `dout` throughout cycle j+DEPTH, where cycle j+1 starts at the rising edge that ends cycle j.
- R3: Cycles with `en` low do not count toward the delay. A word emerges after DEPTH enabled cycles, however many disabled cycles fall in between.
- R4: While `en` is low, `dout` holds its value, and a `din` value presented on that cycle is never stored and never appears at the output.
- R5: Two instances in series, the first with DEPTH 8 and the second with DEPTH 32, sharing `en`, give a delay of exactly 40 enabled cycles.
- R6: A DEPTH 32 instance delays each word by 32 enabled cycles.
- R7: The write pointer always holds exactly one set bit and moves one position per enabled cycle, so the delay stays correct over many trips around the ring.
- R8: Asserting `rst_n` low at any time clears `dout` at once and discards every stored word. Output after the synchronized release follows R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Cells capture on the falling edge; the output register and the pointer update on the rising edge. |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously; release is synchronized inside the block. |
| en | input | 1 | Shift enable. When high, one word is written, the oldest word is read, and the pointer advances. |
| din | input | WIDTH | Word to store. Must be stable across the falling edge of an enabled cycle. |
| dout | output | WIDTH | Registered oldest word. |

## Verification
The hardest state to reach from the ports is a pointer that has gone around the ring many times with disabled cycles scattered at random points. In that state, a miscounted or skipped pointer step shows up only as a word emerging one slot early or late, long after the fault. The stimulus combines long fully enabled streams, hundreds of cycles with a random 50% enable, idle runs during which `din` is toggled, and a reset in the middle of a stream. It checks a DEPTH 8 instance, a DEPTH 32 instance and an 8+32 chain together against a history of accepted words indexed by enabled-cycle count.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;
  // Ring position that holds the write token immediately after reset.
  localparam int unsigned RING_START = 0;
  // Width of the reset synchronizer chain.
  localparam int unsigned RST_SYNC_STAGES = 2;
endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync
  import ring_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [RST_SYNC_STAGES-1:0] sync_q;
  logic [RST_SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[RST_SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[RST_SYNC_STAGES-1];
endmodule

// File: rtl/ring_token_ptr.sv
module ring_token_ptr
  import ring_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [DEPTH-1:0] wr_sel,
  output logic [DEPTH-1:0] rd_sel
);
  localparam logic [DEPTH-1:0] TOKEN_INIT = DEPTH'(1) << RING_START;

  logic [DEPTH-1:0] ptr_q;
  logic [DEPTH-1:0] ptr_d;
  logic [DEPTH-1:0] ptr_rot;

  // One step along the ring: bit i moves to bit i+1, the top bit wraps to 0.
  assign ptr_rot = {ptr_q[DEPTH-2:0], ptr_q[DEPTH-1]};

  always_comb begin
    if (en) ptr_d = ptr_rot;
    else    ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= TOKEN_INIT;
    else        ptr_q <= ptr_d;
  end

  // The cell after the write cell holds the oldest word.
  assign wr_sel = ptr_q;
  assign rd_sel = ptr_rot;
endmodule

// File: rtl/ring_cell_array.sv
module ring_cell_array #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [DEPTH-1:0]       wr_sel,
  input  logic [WIDTH-1:0]       din,
  output logic [DEPTH*WIDTH-1:0] cells
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [WIDTH-1:0] cell_q;
    logic [WIDTH-1:0] cell_d;
    logic             cell_we;

    assign cell_we = en & wr_sel[g];

    always_comb begin
      if (cell_we) cell_d = din;
      else         cell_d = cell_q;
    end

    // Capture on the falling edge, half a cycle away from the read edge.
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= '0;
      else        cell_q <= cell_d;
    end

    assign cells[g*WIDTH +: WIDTH] = cell_q;
  end
endmodule

// File: rtl/ring_and_or_read.sv
module ring_and_or_read #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16
) (
  input  logic [DEPTH-1:0]       rd_sel,
  input  logic [DEPTH*WIDTH-1:0] cells,
  output logic [WIDTH-1:0]       rd_word
);
  logic [WIDTH-1:0] gated [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_gate
    assign gated[g] = {WIDTH{rd_sel[g]}} & cells[g*WIDTH +: WIDTH];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_word = rd_word | gated[i];
    end
  end
endmodule

// File: rtl/ring_delay_line.sv
module ring_delay_line #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned CELL_BITS = DEPTH * WIDTH;

  logic                 rst_sync_n;
  logic                 rst_any_n;
  logic [DEPTH-1:0]     wr_sel;
  logic [DEPTH-1:0]     rd_sel;
  logic [CELL_BITS-1:0] cells;
  logic [WIDTH-1:0]     rd_word;
  logic [WIDTH-1:0]     dout_q;
  logic [WIDTH-1:0]     dout_d;

  ring_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Clear immediately when the pin falls; release only after synchronization.
  assign rst_any_n = rst_n & rst_sync_n;

  ring_token_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_any_n),
    .en     (en),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  ring_cell_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_cells (
    .clk    (clk),
    .rst_n  (rst_any_n),
    .en     (en),
    .wr_sel (wr_sel),
    .din    (din),
    .cells  (cells)
  );

  ring_and_or_read #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_read (
    .rd_sel  (rd_sel),
    .cells   (cells),
    .rd_word (rd_word)
  );

  always_comb begin
    if (en) dout_d = rd_word;
    else    dout_d = dout_q;
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) dout_q <= '0;
    else            dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/ring_delay_line_chk.sv
module ring_delay_line_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [DEPTH-1:0] wr_sel,
  input logic [WIDTH-1:0] dout
);
  // R7: exactly one write token on the ring
  a_r7_one_token: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_sel) == 1);

  // R7: an enabled cycle moves the token one place along the ring
  a_r7_token_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (wr_sel == {$past(wr_sel[DEPTH-2:0]), $past(wr_sel[DEPTH-1])}));

  // R3: a disabled cycle leaves the token in place
  a_r3_token_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(wr_sel));

  // R4: the output holds across a disabled cycle
  a_r4_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));
endmodule

bind ring_delay_line ring_delay_line_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_any_n),
  .en     (en),
  .wr_sel (wr_sel),
  .dout   (dout)
);

// File: tb/test_ring_delay_line.sv
`timescale 1ns/1ps
module test_ring_delay_line;
  localparam int W = 16;
  localparam int HMAX = 4096;

  logic         clk;
  logic         rst_n;
  logic         en;
  logic [W-1:0] din;
  logic [W-1:0] dout8, dout32, dmid, dchain;

  int checks = 0;
  int errors = 0;
  int e = 0;
  logic [W-1:0] hist [0:HMAX-1];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  ring_delay_line #(.DEPTH(8), .WIDTH(W)) i_ring_delay_line (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dout8));
  ring_delay_line #(.DEPTH(32), .WIDTH(W)) i_ring_delay_line_d32 (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dout32));
  ring_delay_line #(.DEPTH(8), .WIDTH(W)) i_chain_a (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dmid));
  ring_delay_line #(.DEPTH(32), .WIDTH(W)) i_chain_b (
    .clk(clk), .rst_n(rst_n), .en(en), .din(dmid), .dout(dchain));

  function automatic logic [W-1:0] expect_at(int n);
    if (e >= n) return hist[e-n];
    return '0;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (enabled count %0d)", tag, act, exp, e);
    end
  endtask

  task automatic check_all(string tag);
    check((e < 8)  ? "R1" : tag,  dout8,  expect_at(8));
    check((e < 32) ? "R1" : "R6", dout32, expect_at(32));
    check((e < 40) ? "R1" : "R5", dchain, expect_at(40));
  endtask

  // One cycle: drive after the rising edge, sample before the next one.
  task automatic step(logic en_v, logic [W-1:0] d, string tag);
    @(posedge clk);
    #2;
    en = en_v;
    din = d;
    #4;
    check_all(tag);
    if (en_v) begin
      hist[e] = d;
      e++;
    end
  endtask

  // R8 / R1: reset clears output and storage
  task automatic do_reset();
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    en = 1'b0;
    #4;
    check("R8", dout8, '0);
    check("R8", dout32, '0);
    check("R8", dchain, '0);
    e = 0;
    repeat (2) step(1'b0, 16'hdead, "R8");
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (3) step(1'b0, 16'hbeef, "R1");
  endtask

  initial begin
    rst_n = 1'b0;
    en = 1'b0;
    din = '0;
    #6;
    check("R1", dout8, '0);
    check("R1", dchain, '0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (3) step(1'b0, 16'h0, "R1");

    // R2: continuous stream of random words
    for (int i = 0; i < 100; i++) step(1'b1, W'($urandom), "R2");

    // R3: random enable pattern, delay counts enabled cycles only
    for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 1)), W'($urandom), "R3");

    // R4: long idle stretch with din toggling, then resume
    for (int i = 0; i < 40; i++) step(1'b0, (i % 2) ? 16'hffff : 16'h0000, "R4");
    for (int i = 0; i < 50; i++) step(1'b1, W'(16'h1000 + i), "R4");

    // R8: reset in the middle of a stream
    do_reset();
    for (int i = 0; i < 60; i++) step(1'b1, W'($urandom), "R8");

    // R7: many wraps with structured patterns
    for (int i = 0; i < 640; i++) begin
      logic [W-1:0] p;
      case (i % 4)
        0: p = W'(1) << (i % W);
        1: p = 16'hffff;
        2: p = 16'haaaa;
        default: p = W'(i);
      endcase
      step(1'b1, p, "R7");
    end
    for (int i = 0; i < 200; i++) step(1'($urandom_range(0, 3) != 0), W'($urandom), "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule